// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the combinational hazard controller of a five-stage in-order integer pipeline. Each cycle it looks at the source register numbers in decode and execute, at the destination numbers and write enables further down the pipe, at the result-select field of the instruction in execute and at the redirect flag from branch resolution. From these it produces two operand bypass selects for the execute stage, hold enables for the fetch and decode registers, and squash controls for the decode and execute registers.

A value that an older instruction still in flight has produced reaches a dependent instruction in execute through the bypass selects. The memory-stage producer is preferred because it is newer. Register zero is never bypassed. When a load in execute feeds an instruction in decode, the front of the pipe holds for one cycle and a bubble goes into execute. A taken branch or jump squashes the two wrong-path instructions held in decode and execute. The block has no state, so every output follows its inputs within the same cycle.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: `fwd_a_o` is 2'b10 (memory-stage ALU result) when `ex_rs1_i` equals `mem_rd_i`, `mem_wr_en_i` is 1 and `ex_rs1_i` is not zero.
- R2: When R1 does not apply, `fwd_a_o` is 2'b01 (writeback result) when `ex_rs1_i` equals `wb_rd_i`, `wb_wr_en_i` is 1 and `ex_rs1_i` is not zero.
- R3: In every other case `fwd_a_o` is 2'b00 (register-file value). This covers a source of zero and a match whose write enable is 0.
- R4: `fwd_b_o` follows the rules of R1 to R3, with `ex_rs2_i` in place of `ex_rs1_i`.
- R5: When a source matches both the memory and the writeback destination with both enables set, the select is 2'b10. A select is never 2'b11.
- R6: A load is in execute when bit 0 of `ex_res_sel_i` is 1. Its two encodings are 2'b01 (data memory) and 2'b11. A load-use hazard exists when a load is in execute and `ex_rd_i` equals `dec_rs1_i` or `dec_rs2_i`. Then `stall_fetch_o` and `stall_dec_o` are both 1. Otherwise both are 0.
- R7: `flush_ex_o` is 1 exactly when a load-use hazard exists or `ex_redirect_i` is 1.
- R8: `flush_dec_o` equals `ex_redirect_i`. A redirect alone does not raise either stall output.
- R9: All outputs are combinational functions of the current inputs. Any change appears in the same cycle, with no reset and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1_i | input | 5 | First source register number in decode |
| dec_rs2_i | input | 5 | Second source register number in decode |
| ex_rs1_i | input | 5 | First source register number in execute |
| ex_rs2_i | input | 5 | Second source register number in execute |
| ex_rd_i | input | 5 | Destination register number in execute |
| ex_res_sel_i | input | 2 | Result-select field in execute; bit 0 set means load |
| ex_redirect_i | input | 1 | Branch taken or jump resolved in execute |
| mem_rd_i | input | 5 | Destination register number in memory stage |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | 5 | Destination register number in writeback |
| wb_wr_en_i | input | 1 | Writeback instruction writes a register |
| fwd_a_o | output | 2 | Bypass select for operand A |
| fwd_b_o | output | 2 | Bypass select for operand B |
| stall_fetch_o | output | 1 | Hold the program counter and fetch register |
| stall_dec_o | output | 1 | Hold the decode register |
| flush_dec_o | output | 1 | Squash the decode register |
| flush_ex_o | output | 1 | Squash the execute register |

## Verification
The hardest case to reach is a single cycle in which one source matches both downstream destinations with both enables set, while the other source matches only one of them or matches through register zero. Random register numbers across a 5-bit space almost never line up like that. The stimulus therefore restricts every register number to the values 0 to 3 and sweeps every combination of both sources, both destinations and both enables. Each priority, zero and disabled-write case is hit many times over. A second sweep crosses decode sources, execute destination, all four result-select codes and the redirect flag, so a load-use hazard on each operand also coincides with a taken branch.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   // operand source chosen for execute
   typedef enum logic [1:0] {
      BYP_RF  = 2'b00,
      BYP_WB  = 2'b01,
      BYP_MEM = 2'b10
   } byp_sel_e;

endpackage

// File: rtl/hzd_bypass_sel.sv
module hzd_bypass_sel #(
   parameter int unsigned REG_W      = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_W-1:0] src_i,
   input  logic [REG_W-1:0] mem_rd_i,
   input  logic             mem_we_i,
   input  logic [REG_W-1:0] wb_rd_i,
   input  logic             wb_we_i,
   output logic [1:0]       sel_o
);
   import hzd_pkg::*;

   logic src_live;

   generate
      if (ZERO_GUARD) begin : g_zero_guard
         assign src_live = |src_i;
      end else begin : g_no_guard
         assign src_live = 1'b1;
      end
   endgenerate

   logic hit_mem;
   logic hit_wb;

   assign hit_mem = src_live && mem_we_i && (src_i == mem_rd_i);
   assign hit_wb  = src_live && wb_we_i  && (src_i == wb_rd_i);

   // newer producer checked first
   always_comb begin
      if (hit_mem)     sel_o = BYP_MEM;
      else if (hit_wb) sel_o = BYP_WB;
      else             sel_o = BYP_RF;
   end

endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned RSEL_W   = 2,
   parameter int unsigned LOAD_BIT = 0,
   parameter int unsigned NUM_SRC  = 2
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src_i,
   input  logic [REG_W-1:0]              ex_rd_i,
   input  logic [RSEL_W-1:0]             ex_res_sel_i,
   output logic                          hit_o
);
   localparam logic [RSEL_W-1:0] LOAD_MASK = RSEL_W'(1) << LOAD_BIT;

   logic               is_load;
   logic [NUM_SRC-1:0] src_match;

   assign is_load = (ex_res_sel_i & LOAD_MASK) != '0;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign src_match[i] = (dec_src_i[i] == ex_rd_i);
      end
   endgenerate

   assign hit_o = is_load && (|src_match);

endmodule

// File: rtl/hzd_ctrl_merge.sv
module hzd_ctrl_merge (
   input  logic load_use_i,
   input  logic redirect_i,
   output logic stall_fetch_o,
   output logic stall_dec_o,
   output logic flush_dec_o,
   output logic flush_ex_o
);
   assign stall_fetch_o = load_use_i;
   assign stall_dec_o   = load_use_i;
   assign flush_dec_o   = redirect_i;
   assign flush_ex_o    = load_use_i | redirect_i;
endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit #(
   parameter int unsigned REG_W      = 5,
   parameter int unsigned RSEL_W     = 2,
   parameter int unsigned LOAD_BIT   = 0,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_W-1:0]  dec_rs1_i,
   input  logic [REG_W-1:0]  dec_rs2_i,
   input  logic [REG_W-1:0]  ex_rs1_i,
   input  logic [REG_W-1:0]  ex_rs2_i,
   input  logic [REG_W-1:0]  ex_rd_i,
   input  logic [RSEL_W-1:0] ex_res_sel_i,
   input  logic              ex_redirect_i,
   input  logic [REG_W-1:0]  mem_rd_i,
   input  logic              mem_wr_en_i,
   input  logic [REG_W-1:0]  wb_rd_i,
   input  logic              wb_wr_en_i,
   output logic [1:0]        fwd_a_o,
   output logic [1:0]        fwd_b_o,
   output logic              stall_fetch_o,
   output logic              stall_dec_o,
   output logic              flush_dec_o,
   output logic              flush_ex_o
);
   localparam int unsigned NUM_OPND = 2;

   generate
      if (REG_W < 1) begin : g_bad_regw
         $error("hazard_ctrl_unit: REG_W must be at least 1");
      end
      if (LOAD_BIT >= RSEL_W) begin : g_bad_loadbit
         $error("hazard_ctrl_unit: LOAD_BIT outside result-select field");
      end
   endgenerate

   logic [NUM_OPND-1:0][REG_W-1:0] ex_src;
   logic [NUM_OPND-1:0][REG_W-1:0] dec_src;
   logic [NUM_OPND-1:0][1:0]       byp_sel;
   logic                           load_use;

   assign ex_src[0]  = ex_rs1_i;
   assign ex_src[1]  = ex_rs2_i;
   assign dec_src[0] = dec_rs1_i;
   assign dec_src[1] = dec_rs2_i;

   generate
      for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
         hzd_bypass_sel #(
            .REG_W      (REG_W),
            .ZERO_GUARD (ZERO_GUARD)
         ) u_byp (
            .src_i    (ex_src[k]),
            .mem_rd_i (mem_rd_i),
            .mem_we_i (mem_wr_en_i),
            .wb_rd_i  (wb_rd_i),
            .wb_we_i  (wb_wr_en_i),
            .sel_o    (byp_sel[k])
         );
      end
   endgenerate

   assign fwd_a_o = byp_sel[0];
   assign fwd_b_o = byp_sel[1];

   hzd_load_use #(
      .REG_W    (REG_W),
      .RSEL_W   (RSEL_W),
      .LOAD_BIT (LOAD_BIT),
      .NUM_SRC  (NUM_OPND)
   ) u_lu (
      .dec_src_i    (dec_src),
      .ex_rd_i      (ex_rd_i),
      .ex_res_sel_i (ex_res_sel_i),
      .hit_o        (load_use)
   );

   hzd_ctrl_merge u_merge (
      .load_use_i    (load_use),
      .redirect_i    (ex_redirect_i),
      .stall_fetch_o (stall_fetch_o),
      .stall_dec_o   (stall_dec_o),
      .flush_dec_o   (flush_dec_o),
      .flush_ex_o    (flush_ex_o)
   );

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
   parameter int unsigned REG_W  = 5,
   parameter int unsigned RSEL_W = 2
) (
   input logic [REG_W-1:0]  dec_rs1_i,
   input logic [REG_W-1:0]  dec_rs2_i,
   input logic [REG_W-1:0]  ex_rs1_i,
   input logic [REG_W-1:0]  ex_rs2_i,
   input logic [REG_W-1:0]  ex_rd_i,
   input logic [RSEL_W-1:0] ex_res_sel_i,
   input logic              ex_redirect_i,
   input logic [REG_W-1:0]  mem_rd_i,
   input logic              mem_wr_en_i,
   input logic [REG_W-1:0]  wb_rd_i,
   input logic              wb_wr_en_i,
   input logic [1:0]        fwd_a_o,
   input logic [1:0]        fwd_b_o,
   input logic              stall_fetch_o,
   input logic              stall_dec_o,
   input logic              flush_dec_o,
   input logic              flush_ex_o
);
   always_comb begin
      // R1
      if (ex_rs1_i != '0 && mem_wr_en_i && ex_rs1_i == mem_rd_i)
         fwd_a_mem_chk: assert (fwd_a_o == 2'b10);
      // R3
      if (ex_rs1_i == '0)
         fwd_a_zero_chk: assert (fwd_a_o == 2'b00);
      // R4
      if (ex_rs2_i == '0 || (!mem_wr_en_i && !wb_wr_en_i))
         fwd_b_idle_chk: assert (fwd_b_o == 2'b00);
      // R5
      no_sel11_chk: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11);
      // R6
      stall_pair_chk: assert (stall_fetch_o == stall_dec_o);
      // R7
      if (stall_fetch_o)
         stall_bubble_chk: assert (flush_ex_o);
      // R8
      redirect_flush_chk: assert (flush_dec_o == ex_redirect_i);
      // R7
      if (!ex_redirect_i && !stall_fetch_o)
         flush_ex_quiet_chk: assert (!flush_ex_o);
   end
endmodule

bind hazard_ctrl_unit hazard_ctrl_chk #(
   .REG_W  (REG_W),
   .RSEL_W (RSEL_W)
) u_chk (
   .dec_rs1_i     (dec_rs1_i),
   .dec_rs2_i     (dec_rs2_i),
   .ex_rs1_i      (ex_rs1_i),
   .ex_rs2_i      (ex_rs2_i),
   .ex_rd_i       (ex_rd_i),
   .ex_res_sel_i  (ex_res_sel_i),
   .ex_redirect_i (ex_redirect_i),
   .mem_rd_i      (mem_rd_i),
   .mem_wr_en_i   (mem_wr_en_i),
   .wb_rd_i       (wb_rd_i),
   .wb_wr_en_i    (wb_wr_en_i),
   .fwd_a_o       (fwd_a_o),
   .fwd_b_o       (fwd_b_o),
   .stall_fetch_o (stall_fetch_o),
   .stall_dec_o   (stall_dec_o),
   .flush_dec_o   (flush_dec_o),
   .flush_ex_o    (flush_ex_o)
);

// File: tb/hazard_ctrl_unit_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_unit_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [4:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic [1:0] ex_res_sel;
   logic       ex_redirect, mem_we, wb_we;
   logic [1:0] fwd_a, fwd_b;
   logic       stall_f, stall_d, flush_d, flush_e;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   hazard_ctrl_unit u_dut (
      .dec_rs1_i     (dec_rs1),
      .dec_rs2_i     (dec_rs2),
      .ex_rs1_i      (ex_rs1),
      .ex_rs2_i      (ex_rs2),
      .ex_rd_i       (ex_rd),
      .ex_res_sel_i  (ex_res_sel),
      .ex_redirect_i (ex_redirect),
      .mem_rd_i      (mem_rd),
      .mem_wr_en_i   (mem_we),
      .wb_rd_i       (wb_rd),
      .wb_wr_en_i    (wb_we),
      .fwd_a_o       (fwd_a),
      .fwd_b_o       (fwd_b),
      .stall_fetch_o (stall_f),
      .stall_dec_o   (stall_d),
      .flush_dec_o   (flush_d),
      .flush_ex_o    (flush_e)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_fwd(input int s, input int rm, input int wm,
                                  input int rw, input int ww);
      if (s != 0 && wm == 1 && s == rm) return 2;
      if (s != 0 && ww == 1 && s == rw) return 1;
      return 0;
   endfunction

   function automatic string fwd_tag(input string base, input int s, input int rm,
                                     input int wm, input int rw, input int ww);
      if (s != 0 && wm == 1 && ww == 1 && s == rm && s == rw) return "R5";
      if (s == 0 || ((s == rm || s == rw) && wm == 0 && ww == 0)) return "R3";
      return base;
   endfunction

   initial begin
      // R9: block is stateless; inputs settle, outputs follow in the same cycle
      {dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
      ex_res_sel = 2'b00; ex_redirect = 1'b0; mem_we = 1'b0; wb_we = 1'b0;
      @(negedge clk);
      check("R9 idle fwd_a", fwd_a, 0);
      check("R9 idle fwd_b", fwd_b, 0);
      check("R9 idle stall", {stall_f, stall_d}, 0);
      check("R9 idle flush", {flush_d, flush_e}, 0);

      // forwarding sweep, R1 R2 R3 R4 R5
      for (int s1 = 0; s1 < 4; s1++)
         for (int s2 = 0; s2 < 4; s2++)
            for (int rm = 0; rm < 4; rm++)
               for (int rw = 0; rw < 4; rw++)
                  for (int en = 0; en < 4; en++) begin
                     @(posedge clk);
                     ex_rs1 = 5'(s1); ex_rs2 = 5'(s2);
                     mem_rd = 5'(rm); wb_rd = 5'(rw);
                     mem_we = en[0]; wb_we = en[1];
                     @(negedge clk);
                     check(fwd_tag(exp_fwd(s1, rm, en[0], rw, en[1]) == 2 ? "R1" : "R2",
                                   s1, rm, en[0], rw, en[1]),
                           fwd_a, exp_fwd(s1, rm, en[0], rw, en[1]));
                     check(fwd_tag("R4", s2, rm, en[0], rw, en[1]),
                           fwd_b, exp_fwd(s2, rm, en[0], rw, en[1]));
                  end

      // high register numbers to exercise full width, R1 R4
      @(posedge clk);
      ex_rs1 = 5'd31; ex_rs2 = 5'd17; mem_rd = 5'd31; wb_rd = 5'd17;
      mem_we = 1'b1; wb_we = 1'b1;
      @(negedge clk);
      check("R1 x31", fwd_a, 2);
      check("R4 x17 wb", fwd_b, 1);

      // hazard sweep, R6 R7 R8
      mem_we = 1'b0; wb_we = 1'b0;
      for (int d1 = 0; d1 < 4; d1++)
         for (int d2 = 0; d2 < 4; d2++)
            for (int rd = 0; rd < 4; rd++)
               for (int rs = 0; rs < 4; rs++)
                  for (int br = 0; br < 2; br++) begin
                     bit lu;
                     @(posedge clk);
                     dec_rs1 = 5'(d1); dec_rs2 = 5'(d2); ex_rd = 5'(rd);
                     ex_res_sel = 2'(rs); ex_redirect = br[0];
                     lu = (rs % 2 == 1) && (rd == d1 || rd == d2);
                     @(negedge clk);
                     check("R6 stall_fetch", stall_f, int'(lu));
                     check("R6 stall_dec",   stall_d, int'(lu));
                     check("R7 flush_ex",    flush_e, int'(lu || br == 1));
                     check("R8 flush_dec",   flush_d, br);
                  end

      // R9: change within one cycle, observed before next edge
      @(posedge clk);
      dec_rs1 = 5'd9; dec_rs2 = 5'd4; ex_rd = 5'd9; ex_res_sel = 2'b01; ex_redirect = 1'b0;
      #1;
      check("R9 same-cycle stall", stall_f, 1);
      ex_res_sel = 2'b10;
      #1;
      check("R9 same-cycle release", stall_f, 0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule